// File: doc/BRIEF.md
# Serial Port Line Flow-Control Gate

This block sits between a UART core and the modem-control pins of an asynchronous port that acts as the terminal side (DTE). A five-bit mode register picks which incoming modem lines must be high before a new character may begin transmission. It also picks which outgoing lines, or the outgoing isochronous clock, are used to ask the far end to stop sending while the local receive buffer is nearly full. Setting two lines that serve the same purpose at once is illegal, and the block raises a flag for it.

Two state machines do the work. The transmit gate has the states TX_IDLE, TX_HELD, TX_LAUNCH and TX_SHIFT. A request with permission goes TX_IDLE→TX_LAUNCH. A request without permission goes TX_IDLE→TX_HELD, and then TX_HELD→TX_LAUNCH once permission arrives. If the request is withdrawn or the port closes, TX_HELD→TX_IDLE. TX_LAUNCH→TX_SHIFT always follows, and TX_SHIFT→TX_IDLE happens on the shifter's done pulse.

The receive throttle has the states RX_CLOSED, RX_FLOW and RX_STOP. The port opening moves RX_CLOSED→RX_FLOW. A nearly full buffer with an enabled throttle moves RX_FLOW→RX_STOP. The condition clearing moves RX_STOP→RX_FLOW. The port closing moves either open state to RX_CLOSED. The CTS and CD inputs pass through a two-flop synchronizer before they are used.

Top module: `line_flow_gate`

## Requirements
- R1: The mode register is loaded from `mode_wdata` on a clock with `mode_we` high and resets to zero. Its bits are: bit 0 = RTS input throttle, bit 1 = CTS output gate, bit 2 = DTR input throttle, bit 3 = CD output gate, bit 4 = clock-stop input throttle.
- R2: With bit 0 set, the port open and no input conflict, `rts_out` is high. It goes low one cycle after `rx_near_full` is sampled high, and returns high one cycle after it is sampled low.
- R3: With bit 2 set, the port open and no input conflict, `dtr_out` drops one cycle after `rx_near_full` is sampled high. `rts_out` stays high for connectivity.
- R4: With bit 1 set, `tx_start` is never issued while the synchronized CTS is low. After CTS rises, `tx_start` goes high exactly three cycles later (two synchronizer stages plus the state register).
- R5: With bit 3 set, `tx_start` is never issued while the synchronized CD is low, and a held request is launched once CD rises.
- R6: A character that has started is not cut short by a falling gate line. The block issues one `tx_start` per character and none before `tx_done`. The next start waits for permission again.
- R7: If bits 0 and 2 are both set, `err_in_conflict` is high, and both RTS and DTR stay high even when the buffer is nearly full.
- R8: If bits 1 and 3 are both set, `err_out_conflict` is high, and a start needs both CTS and CD high.
- R9: While `port_en` is low, RTS, DTR and `clk_hold` are low and no start is issued. One cycle after `port_en` is sampled high, RTS and DTR are both high.
- R10: With no output gate bit set, starts are never blocked by CTS or CD. With no input throttle bit set, RTS and DTR stay high while open, whatever `rx_near_full` does.
- R11: With bit 4 set, `clk_hold` is high while the throttle is in force (one cycle after `rx_near_full` is sampled high) and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Port open |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 5 | Mode register write value |
| cts_in | input | 1 | Clear-to-send line from the far end (asynchronous) |
| cd_in | input | 1 | Carrier-detect line from the far end (asynchronous) |
| rx_near_full | input | 1 | Receive buffer level is above the threshold |
| tx_req | input | 1 | UART has a character waiting |
| tx_done | input | 1 | Shifter finished the current character (pulse) |
| tx_start | output | 1 | Begin shifting the next character (one-cycle pulse) |
| rts_out | output | 1 | Request-to-send line drive |
| dtr_out | output | 1 | Terminal-ready line drive |
| clk_hold | output | 1 | Stop the outgoing isochronous clock |
| err_in_conflict | output | 1 | RTS and DTR throttles both enabled |
| err_out_conflict | output | 1 | CTS and CD gates both enabled |

## Verification
If the transmit machine held a wrong state, an extra or missing `tx_start` would appear within one cycle. A start during a blocked window shows a gate leak, and a missing start three cycles after CTS rises shows a lost HELD state. If the receive machine held a wrong state, RTS or DTR would take the wrong level one cycle after `rx_near_full` or `port_en` changes. The bench therefore samples these lines at exact cycle offsets and counts starts over fixed windows.

// File: rtl/flow_pkg.sv
package flow_pkg;
    localparam int MODE_W     = 5;
    localparam int MB_RTS_IN  = 0;
    localparam int MB_CTS_OUT = 1;
    localparam int MB_DTR_IN  = 2;
    localparam int MB_CD_OUT  = 3;
    localparam int MB_CLK_IN  = 4;

    typedef enum logic [1:0] {TX_IDLE, TX_HELD, TX_LAUNCH, TX_SHIFT} tx_state_t;
    typedef enum logic [1:0] {RX_CLOSED, RX_FLOW, RX_STOP} rx_state_t;
endpackage

// File: rtl/flow_sync.sv
module flow_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/flow_tx_gate.sv
module flow_tx_gate
    import flow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic port_en,
    input  logic permit,
    input  logic tx_req,
    input  logic tx_done,
    output logic tx_start
);
    tx_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:   if (port_en && tx_req) nxt = permit ? TX_LAUNCH : TX_HELD;
            TX_HELD:   if (!port_en || !tx_req) nxt = TX_IDLE;
                       else if (permit)         nxt = TX_LAUNCH;
            TX_LAUNCH: nxt = TX_SHIFT;
            TX_SHIFT:  if (tx_done) nxt = TX_IDLE;
            default:   nxt = TX_IDLE;
        endcase
    end

    always_comb begin
        tx_start = (state == TX_LAUNCH);
    end

    // R4 / R5 / R8: a launch only follows a cycle with permission
    a_r4_launch_permitted: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_LAUNCH) |-> $past(permit));
    // R6: a running character is held until the shifter reports done
    a_r6_shift_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_SHIFT && !tx_done) |=> (state == TX_SHIFT));
    // R9: no launch from a closed port
    a_r9_closed_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_en && state != TX_LAUNCH && state != TX_SHIFT) |=> (state != TX_LAUNCH));
endmodule

// File: rtl/flow_rx_throttle.sv
module flow_rx_throttle
    import flow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic port_en,
    input  logic near_full,
    input  logic thr_rts,
    input  logic thr_dtr,
    input  logic thr_clk,
    output logic rts_out,
    output logic dtr_out,
    output logic clk_hold
);
    rx_state_t state, nxt;
    logic      use_rts, use_dtr, any_thr;

    always_comb begin
        use_rts = thr_rts && !thr_dtr;
        use_dtr = thr_dtr && !thr_rts;
        any_thr = use_rts || use_dtr || thr_clk;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_CLOSED;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_CLOSED: if (port_en) nxt = RX_FLOW;
            RX_FLOW:   if (!port_en)                  nxt = RX_CLOSED;
                       else if (near_full && any_thr) nxt = RX_STOP;
            RX_STOP:   if (!port_en)                   nxt = RX_CLOSED;
                       else if (!near_full || !any_thr) nxt = RX_FLOW;
            default:   nxt = RX_CLOSED;
        endcase
    end

    always_comb begin
        rts_out  = 1'b0;
        dtr_out  = 1'b0;
        clk_hold = 1'b0;
        unique case (state)
            RX_CLOSED: ;
            RX_FLOW: begin
                rts_out = 1'b1;
                dtr_out = 1'b1;
            end
            RX_STOP: begin
                rts_out  = !use_rts;
                dtr_out  = !use_dtr;
                clk_hold = thr_clk;
            end
            default: ;
        endcase
    end

    // R2: the throttle state is only entered on a nearly full buffer
    a_r2_stop_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_STOP) |-> $past(near_full));
    // R9: opening the port raises both connectivity lines
    a_r9_open_raises: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(port_en) |=> (rts_out && dtr_out));
    // R7: a conflicting input pair never drops either line
    a_r7_conflict_lines_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state != RX_CLOSED && thr_rts && thr_dtr) |-> (rts_out && dtr_out));
endmodule

// File: rtl/line_flow_gate.sv
module line_flow_gate
    import flow_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              cts_in,
    input  logic              cd_in,
    input  logic              rx_near_full,
    input  logic              tx_req,
    input  logic              tx_done,
    output logic              tx_start,
    output logic              rts_out,
    output logic              dtr_out,
    output logic              clk_hold,
    output logic              err_in_conflict,
    output logic              err_out_conflict
);
    localparam int LINES = 2;

    logic [MODE_W-1:0] mode_q;
    logic [LINES-1:0]  line_s;
    logic              permit;

    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_we) mode_q <= mode_wdata;
    end

    flow_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cd_in, cts_in}),
        .q    (line_s)
    );

    always_comb begin
        permit = (!mode_q[MB_CTS_OUT] || line_s[0]) &&
                 (!mode_q[MB_CD_OUT]  || line_s[1]);
        err_in_conflict  = mode_q[MB_RTS_IN]  && mode_q[MB_DTR_IN];
        err_out_conflict = mode_q[MB_CTS_OUT] && mode_q[MB_CD_OUT];
    end

    flow_tx_gate u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_en (port_en),
        .permit  (permit),
        .tx_req  (tx_req),
        .tx_done (tx_done),
        .tx_start(tx_start)
    );

    flow_rx_throttle u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_en  (port_en),
        .near_full(rx_near_full),
        .thr_rts  (mode_q[MB_RTS_IN]),
        .thr_dtr  (mode_q[MB_DTR_IN]),
        .thr_clk  (mode_q[MB_CLK_IN]),
        .rts_out  (rts_out),
        .dtr_out  (dtr_out),
        .clk_hold (clk_hold)
    );

    // R1 / R7 / R8: a write sets the conflict flags from the written value
    a_r1_in_flag: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (err_in_conflict == ($past(mode_wdata[MB_RTS_IN]) && $past(mode_wdata[MB_DTR_IN]))));
    a_r8_out_flag: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (err_out_conflict == ($past(mode_wdata[MB_CTS_OUT]) && $past(mode_wdata[MB_CD_OUT]))));
endmodule

// File: tb/sim_line_flow_gate.sv
module sim_line_flow_gate;
    localparam int CLK_PERIOD = 10;
    localparam int SHIFT_LEN  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0, mode_we = 1'b0;
    logic [4:0] mode_wdata = '0;
    logic       cts_in = 1'b0, cd_in = 1'b0, rx_near_full = 1'b0, tx_req = 1'b0;
    logic       tx_done = 1'b0;
    logic       tx_start, rts_out, dtr_out, clk_hold, err_in_conflict, err_out_conflict;

    int n_chk = 0, n_bad = 0;
    int n_starts = 0, n_dones = 0, sh_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_flow_gate u0 (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .mode_we(mode_we),
        .mode_wdata(mode_wdata), .cts_in(cts_in), .cd_in(cd_in),
        .rx_near_full(rx_near_full), .tx_req(tx_req), .tx_done(tx_done),
        .tx_start(tx_start), .rts_out(rts_out), .dtr_out(dtr_out),
        .clk_hold(clk_hold), .err_in_conflict(err_in_conflict),
        .err_out_conflict(err_out_conflict)
    );

    // shifter model: a character lasts SHIFT_LEN cycles, then one done pulse
    always @(posedge clk) begin
        if (tx_start) begin
            n_starts <= n_starts + 1;
            sh_cnt   <= SHIFT_LEN;
        end else if (sh_cnt != 0) begin
            sh_cnt <= sh_cnt - 1;
        end
        tx_done <= (sh_cnt == 1);
        if (tx_done) n_dones <= n_dones + 1;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic set_mode(input logic [4:0] m);
        mode_we = 1'b1; mode_wdata = m;
        cyc(1);
        mode_we = 1'b0;
    endtask

    // raise a request, wait up to lim cycles for a start, then drop it
    task automatic try_send(input int lim, output bit got);
        got = 0;
        tx_req = 1'b1;
        for (int i = 0; i < lim && !got; i++) begin
            cyc(1);
            if (tx_start) got = 1;
        end
        tx_req = 1'b0;
        cyc(SHIFT_LEN + 3);
    endtask

    task automatic t_reset;
        chk("R9 reset rts", int'(rts_out), 0);
        chk("R9 reset dtr", int'(dtr_out), 0);
        chk("R1 reset in flag", int'(err_in_conflict), 0);
        chk("R1 reset out flag", int'(err_out_conflict), 0);
        chk("R9 reset start", int'(tx_start), 0);
    endtask

    task automatic t_open;
        bit got;
        tx_req = 1'b1; cyc(6); tx_req = 1'b0;
        chk("R9 closed no start", n_starts, 0);
        port_en = 1'b1; cyc(1);
        chk("R9 open rts", int'(rts_out), 1);
        chk("R9 open dtr", int'(dtr_out), 1);
        try_send(4, got);
        chk("R10 ungated start", int'(got), 1);
        rx_near_full = 1'b1; cyc(3);
        chk("R10 no throttle rts", int'(rts_out), 1);
        chk("R10 no throttle dtr", int'(dtr_out), 1);
        rx_near_full = 1'b0; cyc(1);
    endtask

    task automatic t_rts;
        set_mode(5'b00001);
        chk("R2 rts idle high", int'(rts_out), 1);
        rx_near_full = 1'b1; cyc(1);
        chk("R2 rts dropped", int'(rts_out), 0);
        chk("R2 dtr kept", int'(dtr_out), 1);
        rx_near_full = 1'b0; cyc(1);
        chk("R2 rts restored", int'(rts_out), 1);
    endtask

    task automatic t_dtr;
        set_mode(5'b00100);
        rx_near_full = 1'b1; cyc(1);
        chk("R3 dtr dropped", int'(dtr_out), 0);
        chk("R3 rts connectivity", int'(rts_out), 1);
        rx_near_full = 1'b0; cyc(1);
        chk("R3 dtr restored", int'(dtr_out), 1);
    endtask

    task automatic t_cts;
        int base;
        set_mode(5'b00010);
        cts_in = 1'b0; cyc(4);
        base = n_starts;
        tx_req = 1'b1; cyc(10);
        chk("R4 blocked while cts low", n_starts - base, 0);
        cts_in = 1'b1; cyc(2);
        chk("R4 no start after 2 cycles", int'(tx_start), 0);
        cyc(1);
        chk("R4 start at 3 cycles", int'(tx_start), 1);
        tx_req = 1'b0; cyc(SHIFT_LEN + 3);
    endtask

    task automatic t_cd;
        int base;
        set_mode(5'b01000);
        cts_in = 1'b0; cd_in = 1'b0; cyc(4);
        base = n_starts;
        tx_req = 1'b1; cyc(8);
        chk("R5 blocked while cd low", n_starts - base, 0);
        cd_in = 1'b1; cyc(5);
        chk("R5 start after cd rise", n_starts - base, 1);
        tx_req = 1'b0; cyc(SHIFT_LEN + 3);
    endtask

    task automatic t_midchar;
        int base, dbase;
        bit got;
        set_mode(5'b00010);
        cts_in = 1'b1; cyc(4);
        base = n_starts; dbase = n_dones;
        tx_req = 1'b1;
        for (int i = 0; i < 6 && !got; i++) begin
            cyc(1);
            if (tx_start) got = 1;
        end
        cts_in = 1'b0;
        cyc(14);
        chk("R6 one start per character", n_starts - base, 1);
        chk("R6 character completed", n_dones - dbase, 1);
        cts_in = 1'b1; cyc(5);
        chk("R6 next start after cts", n_starts - base, 2);
        tx_req = 1'b0; cyc(SHIFT_LEN + 3);
    endtask

    task automatic t_conflicts;
        int base;
        set_mode(5'b00101);
        chk("R7 in flag", int'(err_in_conflict), 1);
        chk("R7 out flag clear", int'(err_out_conflict), 0);
        rx_near_full = 1'b1; cyc(2);
        chk("R7 rts kept", int'(rts_out), 1);
        chk("R7 dtr kept", int'(dtr_out), 1);
        rx_near_full = 1'b0; cyc(1);
        set_mode(5'b01010);
        chk("R8 out flag", int'(err_out_conflict), 1);
        chk("R8 in flag clear", int'(err_in_conflict), 0);
        cts_in = 1'b1; cd_in = 1'b0; cyc(4);
        base = n_starts;
        tx_req = 1'b1; cyc(8);
        chk("R8 cd still required", n_starts - base, 0);
        cd_in = 1'b1; cyc(5);
        chk("R8 start with both high", n_starts - base, 1);
        tx_req = 1'b0; cyc(SHIFT_LEN + 3);
    endtask

    task automatic t_clkstop;
        set_mode(5'b10000);
        chk("R11 clock runs", int'(clk_hold), 0);
        rx_near_full = 1'b1; cyc(1);
        chk("R11 clock held", int'(clk_hold), 1);
        chk("R11 rts untouched", int'(rts_out), 1);
        rx_near_full = 1'b0; cyc(1);
        chk("R11 clock released", int'(clk_hold), 0);
    endtask

    task automatic t_close;
        int base;
        set_mode(5'b10101);
        rx_near_full = 1'b1;
        port_en = 1'b0; cyc(1);
        chk("R9 closed rts", int'(rts_out), 0);
        chk("R9 closed dtr", int'(dtr_out), 0);
        chk("R9 closed clk_hold", int'(clk_hold), 0);
        base = n_starts;
        tx_req = 1'b1; cyc(6); tx_req = 1'b0;
        chk("R9 closed no start", n_starts - base, 0);
        rx_near_full = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_open();
        t_rts();
        t_dtr();
        t_cts();
        t_cd();
        t_midchar();
        t_conflicts();
        t_clkstop();
        t_close();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule